// File: doc/BRIEF.md
# Double-Precision to Integer Converter

This block turns an IEEE-754 binary64 operand into a 64-bit two's-complement integer in a two-stage pipeline. The first stage decodes the operand, puts back the hidden bit and aligns the significand. Alignment produces an integer magnitude and a 64-bit word that holds the discarded fraction bits, with the first discarded bit at bit 63. The second stage applies the selected rounding to the magnitude. It then takes the two's complement for negative operands and sets the status flags.

Results that do not fit are not clamped. The low 64 bits of the exact integer are returned, so the same operation also gives unsigned conversion of values up to 2^64. Every accepted operand produces one result two clock edges later, and the unit never stalls. The caller picks one of four rounding modes per operand. The caller can also force truncation for that operand, and can ask that subnormal inputs be treated as zero.

Top module: `dbl2int_cvt`

## Requirements
- R1: An operand with an all-ones exponent (infinity or NaN) gives result 0 with out_inv set, and out_iov and out_ine clear.
- R2: out_vld rises exactly two rising clock edges after the edge that samples in_vld high, with no backpressure. While out_vld is low, out_res and all three flags are 0. After reset, out_vld is 0.
- R3: A zero operand gives 0 with no flags. A subnormal operand with in_ftz=1 also gives 0 with no flags.
- R4: A subnormal operand with in_ftz=0 is treated as a value below one unit in the last place: out_ine is set and the result is rounded according to the mode. For example, +min subnormal rounds up to 1, and -min subnormal rounds down to all ones.
- R5: An in-range operand with no fraction bits converts exactly, with no flags (100.0 gives 100, -7.0 gives -7, 2^53 gives 2^53).
- R6: When the unbiased exponent minus 52 is 11 or more, out_iov and out_ine are both set and the result is the low 64 bits of the exact value, negated if the sign is 1 (2^63 gives 0x8000000000000000, 1.5*2^63 gives 0xC000000000000000, 2^64 gives 0).
- R7: The operand 0xC3E0000000000000 (-2^63) gives 0x8000000000000000 with no flags.
- R8: When the left shift is 64 or more, the result is 0, with out_iov and out_ine set.
- R9: Any nonzero discarded fraction sets out_ine. Rounding acts on the magnitude, and the result is negated afterwards.
- R10: in_rmode 2'b00 rounds to nearest with ties going to even (0.5 gives 0, 1.5 gives 2, 2.5 gives 2, 3.5 gives 4, 2.75 gives 3).
- R11: in_rmode 2'b01 rounds toward minus infinity, 2'b10 toward plus infinity, and 2'b11 toward zero (-2.5 gives -3, -2, -2 in that order).
- R12: in_trunc=1 rounds toward zero regardless of in_rmode (2.75 with mode 2'b00 gives 2).
- R13: When the right shift is 63 or more, the integer part is 0 and only a sticky bit remains: 2^-20 gives 1 under mode 2'b10 and 0 under mode 2'b00, with out_ine set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Operand valid |
| in_op | input | 64 | binary64 operand |
| in_rmode | input | 2 | Rounding mode: 00 nearest-even, 01 down, 10 up, 11 toward zero |
| in_trunc | input | 1 | Force round toward zero |
| in_ftz | input | 1 | Treat subnormal inputs as zero |
| out_vld | output | 1 | Result valid |
| out_res | output | 64 | Integer result (low 64 bits) |
| out_inv | output | 1 | Invalid operand flag |
| out_iov | output | 1 | Integer overflow flag |
| out_ine | output | 1 | Inexact flag |

## Verification
The hardest cases to reach from the ports are the edges of the alignment range. These are operands whose right shift reaches 63 or more, so that only the sticky bit survives, and operands whose left shift lies between 11 and 63, where the wrapped result is still nonzero. The stimulus picks exponents on each side of those edges: 2^-20, 0.5, 2^53, 2^63, 1.5*2^63, 2^64 and 2^116. It also sends the lone exempt pattern for -2^63, and drives the tiny and tie cases under every rounding mode with both signs. Operands are sent back to back and with gaps, so that the two-cycle latency is checked whether the pipeline is full or draining.

// File: rtl/dbl2int_pkg.sv
package dbl2int_pkg;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int INT_W  = 64;
    localparam int MANT_W = FRAC_W + 1;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int ALIGN  = BIAS + FRAC_W;          // exponent giving a shift of 0
    localparam int OVF_SH = INT_W - MANT_W;         // left shift that overflows

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    typedef struct packed {
        logic             vld;
        logic             sgn;
        logic [INT_W-1:0] mag;
        logic [INT_W-1:0] rnd;
        logic             inv;
        logic             iov;
        rmode_e           mode;
    } align_t;

    typedef struct packed {
        logic             vld;
        logic [INT_W-1:0] res;
        logic             inv;
        logic             iov;
        logic             ine;
    } result_t;
endpackage

// File: rtl/dbl2int_align.sv
module dbl2int_align
    import dbl2int_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vld_i,
    input  logic [EXP_W+FRAC_W:0]   op_i,
    input  logic [1:0]              rmode_i,
    input  logic                    trunc_i,
    input  logic                    ftz_i,
    output align_t                  al_o
);
    localparam logic [EXP_W-1:0]        EXP_MAX = '1;
    localparam logic [EXP_W-1:0]        EXP_ALN = EXP_W'(ALIGN);
    localparam logic [EXP_W+FRAC_W:0]   NEG_MIN = {1'b1, EXP_W'(BIAS + INT_W - 1), {FRAC_W{1'b0}}};

    align_t al_d, al_q;

    logic                 sgn;
    logic [EXP_W-1:0]     ex;
    logic [FRAC_W-1:0]    fr;
    logic [MANT_W-1:0]    mant;
    logic [EXP_W-1:0]     lsh;
    logic [EXP_W-1:0]     rsh;
    logic [2*INT_W-1:0]   wide;

    always_comb begin
        sgn  = op_i[EXP_W+FRAC_W];
        ex   = op_i[EXP_W+FRAC_W-1:FRAC_W];
        fr   = op_i[FRAC_W-1:0];
        mant = {1'b1, fr};
        lsh  = ex - EXP_ALN;
        rsh  = EXP_ALN - ex;
        wide = {INT_W'(mant), {INT_W{1'b0}}} >> rsh;

        al_d      = '0;
        al_d.vld  = vld_i;
        al_d.sgn  = sgn;
        al_d.mode = trunc_i ? RM_ZERO : rmode_e'(rmode_i);
        if (vld_i) begin
            if (ex == '0) begin
                if (fr != '0 && !ftz_i) al_d.rnd = INT_W'(1);
            end else if (ex == EXP_MAX) begin
                al_d.inv = 1'b1;
            end else if (ex >= EXP_ALN) begin
                if (lsh < EXP_W'(INT_W)) al_d.mag = INT_W'(mant) << lsh[$clog2(INT_W)-1:0];
                if (lsh >= EXP_W'(OVF_SH) && op_i != NEG_MIN) al_d.iov = 1'b1;
            end else if (rsh < EXP_W'(INT_W - 1)) begin
                al_d.mag = wide[2*INT_W-1:INT_W];
                al_d.rnd = wide[INT_W-1:0];
            end else begin
                al_d.rnd = INT_W'(1);
            end
        end else begin
            al_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) al_q <= '0;
        else        al_q <= al_d;
    end

    assign al_o = al_q;
endmodule

// File: rtl/dbl2int_round.sv
module dbl2int_round
    import dbl2int_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  align_t  al_i,
    output result_t rs_o
);
    localparam logic [INT_W-1:0] HALF = {1'b1, {(INT_W-1){1'b0}}};

    result_t rs_d, rs_q;
    logic             inc;
    logic [INT_W-1:0] sum;

    always_comb begin
        unique case (al_i.mode)
            RM_NEAR: inc = (al_i.rnd > HALF) || (al_i.rnd == HALF && al_i.mag[0]);
            RM_DOWN: inc = (al_i.rnd != '0) && al_i.sgn;
            RM_UP:   inc = (al_i.rnd != '0) && !al_i.sgn;
            default: inc = 1'b0;
        endcase
        sum = al_i.mag + INT_W'(inc);

        rs_d = '0;
        if (al_i.vld) begin
            rs_d.vld = 1'b1;
            rs_d.res = al_i.sgn ? (~sum + INT_W'(1)) : sum;
            rs_d.inv = al_i.inv;
            rs_d.iov = al_i.iov;
            rs_d.ine = al_i.iov || (al_i.rnd != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign rs_o = rs_q;

    // R9
    exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (al_i.vld && al_i.rnd == '0 && !al_i.iov) |=> !rs_q.ine);
endmodule

// File: rtl/dbl2int_cvt.sv
module dbl2int_cvt
    import dbl2int_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_vld,
    input  logic [63:0] in_op,
    input  logic [1:0]  in_rmode,
    input  logic        in_trunc,
    input  logic        in_ftz,
    output logic        out_vld,
    output logic [63:0] out_res,
    output logic        out_inv,
    output logic        out_iov,
    output logic        out_ine
);
    align_t  al;
    result_t rs;

    dbl2int_align u_align (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (in_vld),
        .op_i    (in_op),
        .rmode_i (in_rmode),
        .trunc_i (in_trunc),
        .ftz_i   (in_ftz),
        .al_o    (al)
    );

    dbl2int_round u_round (
        .clk   (clk),
        .rst_n (rst_n),
        .al_i  (al),
        .rs_o  (rs)
    );

    assign out_vld = rs.vld;
    assign out_res = rs.res;
    assign out_inv = rs.inv;
    assign out_iov = rs.iov;
    assign out_ine = rs.ine;

    // R1
    inv_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_inv |-> (out_res == '0 && !out_iov && !out_ine));
    // R6
    iov_ine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_iov |-> out_ine);
    // R2
    lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(in_vld, 2));
    // R2
    idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (out_res == '0 && !out_inv && !out_iov && !out_ine));
endmodule

// File: tb/tb_dbl2int_cvt.sv
module tb_dbl2int_cvt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [63:0] in_op = '0;
    logic [1:0]  in_rmode = '0;
    logic        in_trunc = 1'b0;
    logic        in_ftz = 1'b0;
    logic        out_vld;
    logic [63:0] out_res;
    logic        out_inv, out_iov, out_ine;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] res;
        logic        inv;
        logic        iov;
        logic        ine;
        int          cyc;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dbl2int_cvt dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
        .in_rmode(in_rmode), .in_trunc(in_trunc), .in_ftz(in_ftz),
        .out_vld(out_vld), .out_res(out_res), .out_inv(out_inv),
        .out_iov(out_iov), .out_ine(out_ine)
    );

    task automatic send(input logic [63:0] op, input logic [1:0] md, input logic tr,
                        input logic fz, input logic [63:0] r, input logic fi,
                        input logic fo, input logic fx, input string tag);
        exp_t e;
        @(negedge clk);
        in_vld = 1'b1; in_op = op; in_rmode = md; in_trunc = tr; in_ftz = fz;
        e.res = r; e.inv = fi; e.iov = fo; e.ine = fx; e.cyc = cyc; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0; in_op = '0;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            exp_t e;
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R2 unexpected result res=%h expected no output", out_res);
            end else begin
                e = sb.pop_front();
                if (out_res !== e.res || out_inv !== e.inv || out_iov !== e.iov ||
                    out_ine !== e.ine || (cyc - e.cyc) != 2) begin
                    bad++;
                    $display("FAIL %s res=%h inv=%b iov=%b ine=%b lat=%0d expected res=%h inv=%b iov=%b ine=%b lat=2",
                             e.tag, out_res, out_inv, out_iov, out_ine, cyc - e.cyc,
                             e.res, e.inv, e.iov, e.ine);
                end
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        total++;
        if (out_vld !== 1'b0 || out_res !== '0 || out_inv || out_iov || out_ine) begin
            bad++;
            $display("FAIL R2 reset state vld=%b res=%h expected vld=0 res=0", out_vld, out_res);
        end
        rst_n = 1'b1;
        // R1 non-finite
        send(64'h7FF0000000000000, 2'b00, 0, 0, 64'h0, 1, 0, 0, "R1 +inf");
        send(64'hFFF8000000000000, 2'b10, 0, 0, 64'h0, 1, 0, 0, "R1 nan");
        // R3 zero and flushed subnormal
        send(64'h0000000000000000, 2'b10, 0, 0, 64'h0, 0, 0, 0, "R3 zero");
        send(64'h0000000000000001, 2'b10, 0, 1, 64'h0, 0, 0, 0, "R3 ftz subnormal");
        gap(1);
        // R4 subnormal sticky
        send(64'h0000000000000001, 2'b10, 0, 0, 64'h1, 0, 0, 1, "R4 +sub up");
        send(64'h0000000000000001, 2'b00, 0, 0, 64'h0, 0, 0, 1, "R4 +sub near");
        send(64'h8000000000000001, 2'b01, 0, 0, 64'hFFFFFFFFFFFFFFFF, 0, 0, 1, "R4 -sub down");
        send(64'h8000000000000001, 2'b10, 0, 0, 64'h0, 0, 0, 1, "R4 -sub up");
        // R5 exact
        send(64'h4059000000000000, 2'b00, 0, 0, 64'd100, 0, 0, 0, "R5 100");
        send(64'hC01C000000000000, 2'b01, 0, 0, 64'hFFFFFFFFFFFFFFF9, 0, 0, 0, "R5 -7");
        send(64'h4340000000000000, 2'b10, 0, 0, 64'h0020000000000000, 0, 0, 0, "R5 2^53");
        gap(3);
        // R6 wrapped overflow
        send(64'h43E0000000000000, 2'b00, 0, 0, 64'h8000000000000000, 0, 1, 1, "R6 2^63");
        send(64'h43E8000000000000, 2'b00, 0, 0, 64'hC000000000000000, 0, 1, 1, "R6 1.5*2^63");
        send(64'h43F0000000000000, 2'b00, 0, 0, 64'h0, 0, 1, 1, "R6 2^64");
        // R7 exempt pattern
        send(64'hC3E0000000000000, 2'b00, 0, 0, 64'h8000000000000000, 0, 0, 0, "R7 -2^63");
        // R8 huge shift
        send(64'h4730000000000000, 2'b00, 0, 0, 64'h0, 0, 1, 1, "R8 2^116");
        // R10 nearest-even, R9 inexact
        send(64'h3FE0000000000000, 2'b00, 0, 0, 64'd0, 0, 0, 1, "R10 0.5");
        send(64'h3FF8000000000000, 2'b00, 0, 0, 64'd2, 0, 0, 1, "R10 1.5");
        send(64'h4004000000000000, 2'b00, 0, 0, 64'd2, 0, 0, 1, "R10 2.5");
        send(64'h400C000000000000, 2'b00, 0, 0, 64'd4, 0, 0, 1, "R10 3.5");
        send(64'h4006000000000000, 2'b00, 0, 0, 64'd3, 0, 0, 1, "R10 2.75");
        gap(2);
        // R11 directed modes on negative, R9 negate after rounding
        send(64'hC004000000000000, 2'b01, 0, 0, 64'hFFFFFFFFFFFFFFFD, 0, 0, 1, "R11 -2.5 down");
        send(64'hC004000000000000, 2'b10, 0, 0, 64'hFFFFFFFFFFFFFFFE, 0, 0, 1, "R11 -2.5 up");
        send(64'hC004000000000000, 2'b11, 0, 0, 64'hFFFFFFFFFFFFFFFE, 0, 0, 1, "R11 -2.5 zero");
        send(64'hC004000000000000, 2'b00, 0, 0, 64'hFFFFFFFFFFFFFFFE, 0, 0, 1, "R9 -2.5 near");
        // R12 force truncate
        send(64'h4006000000000000, 2'b00, 1, 0, 64'd2, 0, 0, 1, "R12 2.75 trunc");
        send(64'h4006000000000000, 2'b10, 1, 0, 64'd2, 0, 0, 1, "R12 2.75 up trunc");
        // R13 tiny normal
        send(64'h3EB0000000000000, 2'b10, 0, 0, 64'd1, 0, 0, 1, "R13 2^-20 up");
        send(64'h3EB0000000000000, 2'b00, 0, 0, 64'd0, 0, 0, 1, "R13 2^-20 near");
        send(64'hBEB0000000000000, 2'b01, 0, 0, 64'hFFFFFFFFFFFFFFFF, 0, 0, 1, "R13 -2^-20 down");
        gap(4);
        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R2 missing results left=%0d expected 0", sb.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog expired expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule